// File: doc/BRIEF.md
# Speculative Pointer-Chasing Load Issue

This block sits in front of the first stage of a load pipeline and selects the address sent to the translation buffer and the data cache each cycle. A normal stage-0 load always wins. When stage 0 is empty in a cycle, the last load stage may be writing back a valid result while a dependent load's immediate offset is also known. In that case the block treats the returning data as a pointer: it adds the sign-extended offset to it and issues that address at once. The aim is to hide the latency of a linked-list style walk.

The early request is allowed only when the addition leaves the cache set-index field of the base untouched. A wrong guess then costs nothing in set selection. One cycle after issue, the block compares the load that actually dispatched against the guess: its base register against the writeback destination, and its offset against the offset that was used. It raises either a confirm or a cancel. A cancelled guess has no architectural effect, and the real load goes through the normal path.

Top module: `ptrchase_spec_issue`

## Requirements
- R1: When `s0_vld` is 1, in the same cycle `req_vld`=1, `req_spec`=0 and `req_addr` = `s0_base` + sign-extended `s0_off`.
- R2: A normal stage-0 load has priority: with `s0_vld`=1, `req_spec` stays 0 even when a writeback and a candidate offset are both valid.
- R3: When `s0_vld`=0, `wb_vld`=1, `cand_vld`=1 and the index field is unchanged, in the same cycle `req_vld`=1, `req_spec`=1 and `req_addr` = `wb_data` + sign-extended `cand_off`.
- R4: The index field is address bits [SET_LO+SET_W-1:SET_LO] (bits 11:6 by default). If the sum differs from `wb_data` in that field, no speculative request is issued and `req_vld`=0.
- R5: With `s0_vld`=0 and either `wb_vld`=0 or `cand_vld`=0, `req_vld`=0 and `req_addr`=0.
- R6: In the cycle after a speculative issue, `spec_ok`=1 and `spec_cancel`=0 if `disp_vld`=1, `disp_rs1` equals the `wb_rd` of the issue cycle, and `disp_off` equals the `cand_off` used.
- R7: In the cycle after a speculative issue, `spec_cancel`=1 and `spec_ok`=0 if any of the three conditions of R6 fails. In the cycle after a cycle without a speculative issue, both are 0.
- R8: While `rst_n` is 0, and in the first cycle after it is released, `spec_ok` and `spec_cancel` are 0.
- R9: Offsets are two's complement, so negative offsets move the address down. A negative offset is speculated whenever the index field still matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s0_vld | input | 1 | Normal load present in stage 0 |
| s0_base | input | ADDR_W | Base address of the normal load |
| s0_off | input | OFF_W | Immediate offset of the normal load |
| wb_vld | input | 1 | Last load stage writes back a valid result |
| wb_data | input | ADDR_W | Writeback data used as the speculative base |
| wb_rd | input | REG_W | Destination register of the writeback |
| cand_vld | input | 1 | A predicted dependent offset is available |
| cand_off | input | OFF_W | Predicted dependent-load offset |
| disp_vld | input | 1 | A load dispatched in the cycle after issue |
| disp_rs1 | input | REG_W | Base register of the dispatched load |
| disp_off | input | OFF_W | Offset of the dispatched load |
| req_vld | output | 1 | Request to translation buffer and data cache |
| req_spec | output | 1 | Request is speculative |
| req_addr | output | ADDR_W | Request address |
| spec_ok | output | 1 | Previous speculative request confirmed |
| spec_cancel | output | 1 | Previous speculative request cancelled |

## Verification
The issue path is driven with writeback bases that sit in the middle of a set-index line, right against its upper and lower edges, and near the top of the address space. Positive and negative offsets are both used, so a correct sign extension can be told apart from a missed carry across the index field. Cases with a normal load present, and with one of the two speculation enables missing, show whether priority and gating are right. The confirm stage is driven with an exact match, a wrong base register, a wrong offset and no dispatch, which shows which of the three compare terms each cancel depends on.

// File: rtl/psi_pkg.sv
package psi_pkg;
   typedef enum logic [1:0] {
      ISS_IDLE = 2'd0,
      ISS_NORM = 2'd1,
      ISS_SPEC = 2'd2
   } iss_src_e;
endpackage

// File: rtl/psi_sext_add.sv
module psi_sext_add #(
   parameter int ADDR_W = 39,
   parameter int OFF_W  = 12
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFF_W-1:0]  off,
   output logic [ADDR_W-1:0] sum
);
   localparam int EXT_W = ADDR_W - OFF_W;
   logic [ADDR_W-1:0] off_ext;

   always_comb begin
      off_ext = {{EXT_W{off[OFF_W-1]}}, off};
      sum     = base + off_ext;
   end
endmodule

// File: rtl/psi_set_guard.sv
module psi_set_guard #(
   parameter int ADDR_W   = 39,
   parameter int OFF_W    = 12,
   parameter int SET_LO   = 6,
   parameter int SET_W    = 6,
   parameter int CHK_MODE = 0
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFF_W-1:0]  off,
   input  logic [ADDR_W-1:0] sum,
   output logic              same_set
);
   localparam int SET_HI = SET_LO + SET_W - 1;

   generate
      if (CHK_MODE == 0) begin : g_exact
         // compare the index field before and after the add
         logic [OFF_W-1:0] off_unused;
         always_comb begin
            off_unused = off;
            same_set   = (sum[SET_HI:SET_LO] == base[SET_HI:SET_LO]);
         end
      end else begin : g_carry_free
         // conservative: non-negative offset within one line, no carry into index
         logic [SET_LO:0]     low_sum;
         logic [ADDR_W-1:0]   sum_unused;
         logic [ADDR_W-1:0]   base_hi_unused;
         always_comb begin
            sum_unused     = sum;
            base_hi_unused = base;
            low_sum        = {1'b0, base[SET_LO-1:0]} + {1'b0, off[SET_LO-1:0]};
            same_set       = ~off[OFF_W-1] && (off[OFF_W-1:SET_LO] == '0) && ~low_sum[SET_LO];
         end
      end
   endgenerate
endmodule

// File: rtl/psi_issue_arb.sv
module psi_issue_arb
   import psi_pkg::*;
#(
   parameter int ADDR_W = 39
) (
   input  logic              s0_vld,
   input  logic [ADDR_W-1:0] norm_addr,
   input  logic              wb_vld,
   input  logic              cand_vld,
   input  logic              same_set,
   input  logic [ADDR_W-1:0] spec_addr,
   output logic              req_vld,
   output logic              req_spec,
   output logic [ADDR_W-1:0] req_addr
);
   iss_src_e src;

   always_comb begin
      if (s0_vld)                           src = ISS_NORM;
      else if (wb_vld && cand_vld && same_set) src = ISS_SPEC;
      else                                  src = ISS_IDLE;

      req_vld  = (src != ISS_IDLE);
      req_spec = (src == ISS_SPEC);
      unique case (src)
         ISS_NORM: req_addr = norm_addr;
         ISS_SPEC: req_addr = spec_addr;
         default:  req_addr = '0;
      endcase
   end
endmodule

// File: rtl/psi_spec_track.sv
module psi_spec_track #(
   parameter int OFF_W = 12,
   parameter int REG_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             spec_issue,
   input  logic [REG_W-1:0] issue_rd,
   input  logic [OFF_W-1:0] issue_off,
   input  logic             disp_vld,
   input  logic [REG_W-1:0] disp_rs1,
   input  logic [OFF_W-1:0] disp_off,
   output logic             spec_ok,
   output logic             spec_cancel
);
   logic             pend_q;
   logic [REG_W-1:0] rd_q;
   logic [OFF_W-1:0] off_q;
   logic             match;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         rd_q   <= '0;
         off_q  <= '0;
      end else begin
         pend_q <= spec_issue;
         if (spec_issue) begin
            rd_q  <= issue_rd;
            off_q <= issue_off;
         end
      end
   end

   always_comb begin
      match       = disp_vld && (disp_rs1 == rd_q) && (disp_off == off_q);
      spec_ok     = pend_q && match;
      spec_cancel = pend_q && !match;
   end
endmodule

// File: rtl/ptrchase_spec_issue.sv
module ptrchase_spec_issue #(
   parameter int ADDR_W   = 39,
   parameter int OFF_W    = 12,
   parameter int REG_W    = 5,
   parameter int SET_LO   = 6,
   parameter int SET_W    = 6,
   parameter int CHK_MODE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s0_vld,
   input  logic [ADDR_W-1:0] s0_base,
   input  logic [OFF_W-1:0]  s0_off,
   input  logic              wb_vld,
   input  logic [ADDR_W-1:0] wb_data,
   input  logic [REG_W-1:0]  wb_rd,
   input  logic              cand_vld,
   input  logic [OFF_W-1:0]  cand_off,
   input  logic              disp_vld,
   input  logic [REG_W-1:0]  disp_rs1,
   input  logic [OFF_W-1:0]  disp_off,
   output logic              req_vld,
   output logic              req_spec,
   output logic [ADDR_W-1:0] req_addr,
   output logic              spec_ok,
   output logic              spec_cancel
);
   generate
      if (OFF_W >= ADDR_W)           begin : g_bad_off  $error("OFF_W must be below ADDR_W"); end
      if (SET_LO + SET_W > ADDR_W)   begin : g_bad_set  $error("index field exceeds address"); end
      if (SET_LO < 1 || SET_W < 1)   begin : g_bad_fld  $error("index field must be non-empty"); end
      if (CHK_MODE == 1 && OFF_W <= SET_LO) begin : g_bad_mode $error("carry-free mode needs OFF_W > SET_LO"); end
      if (CHK_MODE < 0 || CHK_MODE > 1) begin : g_bad_chk $error("CHK_MODE must be 0 or 1"); end
   endgenerate

   logic [ADDR_W-1:0] norm_addr;
   logic [ADDR_W-1:0] spec_addr;
   logic              same_set;

   psi_sext_add #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_norm_add (
      .base(s0_base), .off(s0_off), .sum(norm_addr)
   );

   psi_sext_add #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_spec_add (
      .base(wb_data), .off(cand_off), .sum(spec_addr)
   );

   psi_set_guard #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SET_LO(SET_LO), .SET_W(SET_W), .CHK_MODE(CHK_MODE)
   ) u_guard (
      .base(wb_data), .off(cand_off), .sum(spec_addr), .same_set(same_set)
   );

   psi_issue_arb #(.ADDR_W(ADDR_W)) u_arb (
      .s0_vld(s0_vld), .norm_addr(norm_addr),
      .wb_vld(wb_vld), .cand_vld(cand_vld), .same_set(same_set), .spec_addr(spec_addr),
      .req_vld(req_vld), .req_spec(req_spec), .req_addr(req_addr)
   );

   psi_spec_track #(.OFF_W(OFF_W), .REG_W(REG_W)) u_track (
      .clk(clk), .rst_n(rst_n),
      .spec_issue(req_spec), .issue_rd(wb_rd), .issue_off(cand_off),
      .disp_vld(disp_vld), .disp_rs1(disp_rs1), .disp_off(disp_off),
      .spec_ok(spec_ok), .spec_cancel(spec_cancel)
   );
endmodule

// File: rtl/psi_chk.sv
module psi_chk #(
   parameter int ADDR_W = 39,
   parameter int SET_LO = 6,
   parameter int SET_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              s0_vld,
   input logic              wb_vld,
   input logic              cand_vld,
   input logic [ADDR_W-1:0] wb_data,
   input logic              req_vld,
   input logic              req_spec,
   input logic [ADDR_W-1:0] req_addr,
   input logic              spec_ok,
   input logic              spec_cancel
);
   localparam int SET_HI = SET_LO + SET_W - 1;

   p_norm_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      s0_vld |-> (req_vld && !req_spec));

   p_spec_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_spec |-> (wb_vld && cand_vld && !s0_vld && req_vld));

   p_same_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_spec |-> (req_addr[SET_HI:SET_LO] == wb_data[SET_HI:SET_LO]));

   p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!s0_vld && !(wb_vld && cand_vld)) |-> !req_vld);

   p_resolve_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_spec |=> (spec_ok != spec_cancel));

   p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(spec_ok && spec_cancel));

   p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (spec_ok || spec_cancel) |-> $past(req_spec));
endmodule

bind ptrchase_spec_issue psi_chk #(.ADDR_W(ADDR_W), .SET_LO(SET_LO), .SET_W(SET_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .s0_vld(s0_vld), .wb_vld(wb_vld), .cand_vld(cand_vld),
   .wb_data(wb_data), .req_vld(req_vld), .req_spec(req_spec), .req_addr(req_addr),
   .spec_ok(spec_ok), .spec_cancel(spec_cancel)
);

// File: tb/sim_ptrchase_spec_issue.sv
module sim_ptrchase_spec_issue;
   localparam int AW = 39;
   localparam int OW = 12;
   localparam int RW = 5;
   localparam int VW = 1 + AW + OW + 1 + AW + 1 + OW + 1 + 1 + AW;
   localparam int NV = 10;

   // {s0_vld, s0_base, s0_off, wb_vld, wb_data, cand_vld, cand_off, e_vld, e_spec, e_addr}
   localparam logic [VW-1:0] TBL [NV] = '{
      {1'b1, 39'h1000,       12'h010, 1'b0, 39'h0,          1'b0, 12'h000, 1'b1, 1'b0, 39'h1010},       // R1
      {1'b1, 39'h2000,       12'hFF0, 1'b1, 39'h5000,       1'b1, 12'h008, 1'b1, 1'b0, 39'h1FF0},       // R2 R9
      {1'b0, 39'h0,          12'h000, 1'b1, 39'h40000040,   1'b1, 12'h008, 1'b1, 1'b1, 39'h40000048},   // R3
      {1'b0, 39'h0,          12'h000, 1'b1, 39'h40000078,   1'b1, 12'h008, 1'b0, 1'b0, 39'h0},          // R4
      {1'b0, 39'h0,          12'h000, 1'b1, 39'h40000048,   1'b1, 12'hFF8, 1'b1, 1'b1, 39'h40000040},   // R9
      {1'b0, 39'h0,          12'h000, 1'b1, 39'h40000040,   1'b1, 12'hFF8, 1'b0, 1'b0, 39'h0},          // R4
      {1'b0, 39'h0,          12'h000, 1'b0, 39'h40000040,   1'b1, 12'h008, 1'b0, 1'b0, 39'h0},          // R5
      {1'b0, 39'h0,          12'h000, 1'b1, 39'h40000040,   1'b0, 12'h008, 1'b0, 1'b0, 39'h0},          // R5
      {1'b0, 39'h0,          12'h000, 1'b1, 39'h7FFFFFFFC0, 1'b1, 12'h03C, 1'b1, 1'b1, 39'h7FFFFFFFFC}, // R3
      {1'b0, 39'h0,          12'h000, 1'b1, 39'h1000,       1'b1, 12'h7FF, 1'b0, 1'b0, 39'h0}           // R4
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic          s0_vld, wb_vld, cand_vld, disp_vld;
   logic [AW-1:0] s0_base, wb_data;
   logic [OW-1:0] s0_off, cand_off, disp_off;
   logic [RW-1:0] wb_rd, disp_rs1;
   logic          req_vld, req_spec, spec_ok, spec_cancel;
   logic [AW-1:0] req_addr;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   ptrchase_spec_issue u0 (
      .clk(clk), .rst_n(rst_n),
      .s0_vld(s0_vld), .s0_base(s0_base), .s0_off(s0_off),
      .wb_vld(wb_vld), .wb_data(wb_data), .wb_rd(wb_rd),
      .cand_vld(cand_vld), .cand_off(cand_off),
      .disp_vld(disp_vld), .disp_rs1(disp_rs1), .disp_off(disp_off),
      .req_vld(req_vld), .req_spec(req_spec), .req_addr(req_addr),
      .spec_ok(spec_ok), .spec_cancel(spec_cancel)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      s0_vld = 0; s0_base = '0; s0_off = '0;
      wb_vld = 0; wb_data = '0; wb_rd = '0;
      cand_vld = 0; cand_off = '0;
      disp_vld = 0; disp_rs1 = '0; disp_off = '0;
   endtask

   // issue a speculative request, then present a dispatch in the next cycle
   task automatic spec_then(input logic dv, input logic [RW-1:0] rs, input logic [OW-1:0] doff,
                            input logic e_ok, input string req);
      @(negedge clk);
      idle_inputs();
      wb_vld = 1; wb_data = 39'h80000100; wb_rd = 5'd7; cand_vld = 1; cand_off = 12'h010;
      #1 check("R3 spec issue", {63'd0, req_spec}, 64'd1);
      @(negedge clk);
      idle_inputs();
      disp_vld = dv; disp_rs1 = rs; disp_off = doff;
      #1;
      check({req, " ok"},     {63'd0, spec_ok},     {63'd0, e_ok});
      check({req, " cancel"}, {63'd0, spec_cancel}, {63'd0, ~e_ok});
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      rst_n = 0;
      // R8: during reset, drive a would-be speculation
      @(negedge clk);
      wb_vld = 1; wb_data = 39'h40; cand_vld = 1; cand_off = 12'h4; wb_rd = 5'd1;
      @(negedge clk);
      #1 check("R8 reset ok",     {63'd0, spec_ok},     64'd0);
      check("R8 reset cancel",    {63'd0, spec_cancel}, 64'd0);
      @(negedge clk);
      idle_inputs();
      rst_n = 1;
      #1 check("R8 after reset cancel", {63'd0, spec_cancel}, 64'd0);

      for (int i = 0; i < NV; i++) begin
         logic [VW-1:0] v;
         v = TBL[i];
         @(negedge clk);
         {s0_vld, s0_base, s0_off, wb_vld, wb_data, cand_vld, cand_off} = v[VW-1:AW+2];
         wb_rd = 5'd3; disp_vld = 0; disp_rs1 = '0; disp_off = '0;
         #1;
         check($sformatf("R1-5 row%0d vld", i),  {63'd0, req_vld},  {63'd0, v[AW+1]});
         check($sformatf("R2/R3 row%0d spec", i), {63'd0, req_spec}, {63'd0, v[AW]});
         check($sformatf("R9 row%0d addr", i),   {25'd0, req_addr}, {25'd0, v[AW-1:0]});
      end

      // R6 exact match confirms
      spec_then(1'b1, 5'd7, 12'h010, 1'b1, "R6 match");
      // R7 wrong base register
      spec_then(1'b1, 5'd8, 12'h010, 1'b0, "R7 rs mismatch");
      // R7 wrong offset
      spec_then(1'b1, 5'd7, 12'h018, 1'b0, "R7 off mismatch");
      // R7 no dispatch
      spec_then(1'b0, 5'd7, 12'h010, 1'b0, "R7 no dispatch");

      // R7 quiet after a normal issue even with a matching dispatch
      @(negedge clk);
      idle_inputs();
      s0_vld = 1; s0_base = 39'h300; wb_vld = 1; wb_data = 39'h100; wb_rd = 5'd7;
      cand_vld = 1; cand_off = 12'h010;
      @(negedge clk);
      idle_inputs();
      disp_vld = 1; disp_rs1 = 5'd7; disp_off = 12'h010;
      #1 check("R7 quiet ok",     {63'd0, spec_ok},     64'd0);
      check("R7 quiet cancel",    {63'd0, spec_cancel}, 64'd0);

      // R2 writeback ignored under normal load: address reflects s0 only
      @(negedge clk);
      idle_inputs();
      s0_vld = 1; s0_base = 39'h7FFFFFFFF0; s0_off = 12'h00F;
      wb_vld = 1; wb_data = 39'h40; cand_vld = 1; cand_off = 12'h4;
      #1 check("R2 addr", {25'd0, req_addr}, {25'd0, 39'h7FFFFFFFFF});

      @(negedge clk);
      idle_inputs();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule